// File: doc/BRIEF.md
# Trimmable Nanosecond Time Counter

This block keeps a free-running time count in nanoseconds for precision time protocol hardware. On every enabled clock it adds a programmable step, normally the clock period in nanoseconds. It can also substitute a second, trim step once every programmable number of clocks. A trim step larger than the normal one makes the clock run fast, and a smaller one makes it run slow. This gives fine frequency steering without changing the reference clock.

Software controls the block through a small word-wide register port. The count can wrap at a programmable limit, or it can wrap naturally at its full width. Software sees the live count only through a capture command, which copies it into a readable holding register. Software sets a new time with a direct write. A one-cycle overflow pulse marks every wrap, so that downstream compare logic can follow period boundaries.

Top module: `ns_timer_core`

## Requirements
- R1: While reset is asserted, and right after it, every readable register returns 0, the count is 0 and `ovf_pulse` is low.
- R2: With control bit 0 (run) clear, the count holds its value.
- R3: With run set and no trim due, the count grows each clock by the normal step held in bits 6:0 of the step register (address 4).
- R4: With a trim interval N (address 3) other than zero, the trim step in bits 14:8 of the step register replaces the normal step on one clock out of every N+1. The first substitution falls on the (N+1)-th running clock after the interval counter was cleared.
- R5: A trim interval of 0 turns trimming off, so only the normal step is used.
- R6: With control bit 4 set, when count plus step reaches or passes the limit register (address 2), the count becomes count plus step minus the limit. `ovf_pulse` is high for the clock after that update.
- R7: With control bit 4 clear, the count wraps modulo 2^32, and `ovf_pulse` goes high for one clock after each carry out.
- R8: Writing control with bit 11 set copies the count into the time register (address 1, read only through capture) on the next clock. Bit 11 then reads 0, and the captured value does not change until the next capture.
- R9: A write to address 1 loads the count with the written value on that clock. It takes priority over restart and stepping, and it raises no overflow pulse.
- R10: Writing control with bit 9 set clears the count and the trim interval counter on the next clock. Bit 9 then reads 0.
- R11: Control keeps bits 0, 4, 5, 7, 9, 11 and 13 as written and reads 0 elsewhere. Reads of addresses 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0 control, 1 time, 2 limit, 3 trim interval, 4 steps |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address, same map |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| ovf_pulse | output | 1 | One-clock pulse after each wrap of the count |

## Verification
A wrong step or trim interval shows at the first capture after the fault, as a time value off by the step difference. It also moves the overflow pulse by one or more clocks from where the reference expects it. A stuck self-clearing bit shows on the next control read, or as repeated restarts that freeze captured values at small numbers. The bench compares the read port and the overflow pulse with its own model on every clock and captures every few clocks, so most faults appear within a handful of cycles.

// File: rtl/ns_timer_pkg.sv
package ns_timer_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_TIME   = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_LIMIT  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_TRIM   = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_STEPS  = 3'd4;

  localparam int B_RUN     = 0;
  localparam int B_WRAPLIM = 4;
  localparam int B_RESTART = 9;
  localparam int B_CAPTURE = 11;

  localparam logic [DATA_W-1:0] CTRL_KEEP  = 32'h0000_2AB1;
  localparam logic [DATA_W-1:0] CTRL_PULSE = 32'h0000_0A00;

  localparam int TRIM_LSB = 8;
endpackage

// File: rtl/ns_timer_regs.sv
module ns_timer_regs
  import ns_timer_pkg::*;
#(
  parameter int CW = 32,
  parameter int IW = 7,
  parameter int PW = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [CW-1:0]     cnt_now,
  output logic              run,
  output logic              wrap_lim,
  output logic [CW-1:0]     limit,
  output logic [PW-1:0]     trim_per,
  output logic [IW-1:0]     step_norm,
  output logic [IW-1:0]     step_trim,
  output logic              load_evt,
  output logic [CW-1:0]     load_val,
  output logic              cap_evt,
  output logic              rst_evt,
  output logic [CW-1:0]     cap_val
);
  logic [DATA_W-1:0] ctrl_q;
  logic              wr_ctrl;

  assign wr_ctrl   = wr_en && (wr_addr == ADR_CTRL);
  assign load_evt  = wr_en && (wr_addr == ADR_TIME);
  assign load_val  = wr_data[CW-1:0];
  assign run       = ctrl_q[B_RUN];
  assign wrap_lim  = ctrl_q[B_WRAPLIM];
  assign cap_evt   = ctrl_q[B_CAPTURE];
  assign rst_evt   = ctrl_q[B_RESTART];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      limit     <= '0;
      trim_per  <= '0;
      step_norm <= '0;
      step_trim <= '0;
      cap_val   <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wr_data & CTRL_KEEP;
      else         ctrl_q <= ctrl_q & ~CTRL_PULSE;
      if (wr_en && wr_addr == ADR_LIMIT) limit <= wr_data[CW-1:0];
      if (wr_en && wr_addr == ADR_TRIM)  trim_per <= wr_data[PW-1:0];
      if (wr_en && wr_addr == ADR_STEPS) begin
        step_norm <= wr_data[IW-1:0];
        step_trim <= wr_data[TRIM_LSB +: IW];
      end
      if (cap_evt) cap_val <= cnt_now;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADR_CTRL:  rd_data = ctrl_q;
      ADR_TIME:  rd_data[CW-1:0] = cap_val;
      ADR_LIMIT: rd_data[CW-1:0] = limit;
      ADR_TRIM:  rd_data[PW-1:0] = trim_per;
      ADR_STEPS: begin
        rd_data[IW-1:0]           = step_norm;
        rd_data[TRIM_LSB +: IW]   = step_trim;
      end
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/ns_timer_accum.sv
module ns_timer_accum #(
  parameter int CW = 32,
  parameter int IW = 7,
  parameter int PW = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          wrap_lim,
  input  logic [CW-1:0] limit,
  input  logic [PW-1:0] trim_per,
  input  logic [IW-1:0] step_norm,
  input  logic [IW-1:0] step_trim,
  input  logic          load_evt,
  input  logic [CW-1:0] load_val,
  input  logic          rst_evt,
  output logic [CW-1:0] cnt,
  output logic          trim_hit,
  output logic          wrap_evt,
  output logic          ovf_pulse
);
  localparam int SW = CW + 1;

  function automatic logic [IW-1:0] pick_step(input logic hit,
      input logic [IW-1:0] norm, input logic [IW-1:0] trim);
    return hit ? trim : norm;
  endfunction

  function automatic logic [SW-1:0] add_step(input logic [CW-1:0] c,
      input logic [IW-1:0] s);
    return {1'b0, c} + {{(SW-IW){1'b0}}, s};
  endfunction

  function automatic logic reached(input logic [SW-1:0] sum,
      input logic use_lim, input logic [CW-1:0] lim);
    return use_lim ? (sum >= {1'b0, lim}) : sum[CW];
  endfunction

  logic [PW-1:0] trim_cnt;
  logic [IW-1:0] step;
  logic [SW-1:0] sum;
  logic [SW-1:0] folded;
  logic [CW-1:0] cnt_next;
  logic          trim_on;

  assign trim_on  = (trim_per != '0);
  assign trim_hit = run && trim_on && (trim_cnt >= trim_per);
  assign step     = pick_step(trim_hit, step_norm, step_trim);
  assign sum      = add_step(cnt, step);
  assign wrap_evt = run && reached(sum, wrap_lim, limit);
  assign folded   = sum - {1'b0, limit};
  assign cnt_next = (wrap_lim && wrap_evt) ? folded[CW-1:0] : sum[CW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      trim_cnt  <= '0;
      ovf_pulse <= 1'b0;
    end else begin
      if (load_evt)     cnt <= load_val;
      else if (rst_evt) cnt <= '0;
      else if (run)     cnt <= cnt_next;
      ovf_pulse <= wrap_evt && !load_evt && !rst_evt;
      if (rst_evt)                  trim_cnt <= '0;
      else if (run && !trim_on)     trim_cnt <= '0;
      else if (run && trim_hit)     trim_cnt <= '0;
      else if (run)                 trim_cnt <= trim_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ns_timer_core.sv
module ns_timer_core
  import ns_timer_pkg::*;
#(
  parameter int CW = 32,
  parameter int IW = 7,
  parameter int PW = CW - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              ovf_pulse
);
  logic          run_w, wrap_lim_w, load_evt_w, cap_evt_w, rst_evt_w;
  logic          trim_hit_w, wrap_evt_w;
  logic [CW-1:0] limit_w, load_val_w, cnt_w, cap_val_w;
  logic [PW-1:0] trim_per_w;
  logic [IW-1:0] step_norm_w, step_trim_w;

  ns_timer_regs #(.CW(CW), .IW(IW), .PW(PW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .cnt_now(cnt_w), .run(run_w), .wrap_lim(wrap_lim_w), .limit(limit_w),
    .trim_per(trim_per_w), .step_norm(step_norm_w), .step_trim(step_trim_w),
    .load_evt(load_evt_w), .load_val(load_val_w), .cap_evt(cap_evt_w),
    .rst_evt(rst_evt_w), .cap_val(cap_val_w)
  );

  ns_timer_accum #(.CW(CW), .IW(IW), .PW(PW)) u_accum (
    .clk(clk), .rst_n(rst_n), .run(run_w), .wrap_lim(wrap_lim_w),
    .limit(limit_w), .trim_per(trim_per_w), .step_norm(step_norm_w),
    .step_trim(step_trim_w), .load_evt(load_evt_w), .load_val(load_val_w),
    .rst_evt(rst_evt_w), .cnt(cnt_w), .trim_hit(trim_hit_w),
    .wrap_evt(wrap_evt_w), .ovf_pulse(ovf_pulse)
  );
endmodule

// File: rtl/ns_timer_chk.sv
module ns_timer_chk
  import ns_timer_pkg::*;
#(
  parameter int CW = 32,
  parameter int IW = 7,
  parameter int PW = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              run,
  input logic              load_evt,
  input logic [CW-1:0]     load_val,
  input logic              rst_evt,
  input logic              cap_evt,
  input logic              trim_hit,
  input logic              wrap_evt,
  input logic [PW-1:0]     trim_per,
  input logic [IW-1:0]     step_norm,
  input logic [IW-1:0]     step_trim,
  input logic [CW-1:0]     cnt,
  input logic [CW-1:0]     cap_val,
  input logic              ovf_pulse
);
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load_evt && !rst_evt) |=> $stable(cnt)); // R2
  AST_NORMAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load_evt && !rst_evt && !trim_hit && !wrap_evt)
      |=> (cnt == $past(cnt) + CW'($past(step_norm)))); // R3
  AST_TRIM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load_evt && !rst_evt && trim_hit && !wrap_evt)
      |=> (cnt == $past(cnt) + CW'($past(step_trim)))); // R4
  AST_TRIM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (trim_per == '0) |-> !trim_hit); // R5
  AST_OVF_FOLLOWS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> $past(wrap_evt)); // R6
  AST_CAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(cap_val)); // R8
  AST_CAP_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && !(wr_en && wr_addr == ADR_CTRL)) |=> !cap_evt); // R8
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (cnt == $past(load_val))); // R9
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_evt && !load_evt) |=> (cnt == '0)); // R10
endmodule

bind ns_timer_core ns_timer_chk #(.CW(CW), .IW(IW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .run(run_w), .load_evt(load_evt_w), .load_val(load_val_w),
  .rst_evt(rst_evt_w), .cap_evt(cap_evt_w), .trim_hit(trim_hit_w),
  .wrap_evt(wrap_evt_w), .trim_per(trim_per_w), .step_norm(step_norm_w),
  .step_trim(step_trim_w), .cnt(cnt_w), .cap_val(cap_val_w),
  .ovf_pulse(ovf_pulse)
);

// File: tb/sim_ns_timer_core.sv
`timescale 1ns/1ps
module sim_ns_timer_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        ovf_pulse;

  ns_timer_core u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ovf_pulse(ovf_pulse)
  );

  always #5 clk = ~clk;

  int    vectors = 0;
  int    miscompares = 0;
  bit    started = 0;
  bit    done = 0;
  string phase = "R1 reset";

  // reference state
  longint unsigned m_cnt, m_cap, m_lim, m_trim, m_steps, m_tc, m_ctrl;
  bit m_ovf;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_cap = 0; m_lim = 0; m_trim = 0; m_steps = 0;
      m_tc = 0; m_ctrl = 0; m_ovf = 0;
    end else begin
      bit run, lim_mode, hit, wrapped, ld, rs;
      longint unsigned st, s, nx, n_cnt, n_tc;
      run = m_ctrl[0]; lim_mode = m_ctrl[4]; rs = m_ctrl[9];
      ld = wr_en && wr_addr == 3'd1;
      hit = run && m_trim != 0 && m_tc >= m_trim;
      st = hit ? ((m_steps >> 8) & 64'h7F) : (m_steps & 64'h7F);
      s = m_cnt + st;
      wrapped = run && (lim_mode ? (s >= m_lim) : (s >= 64'h1_0000_0000));
      nx = (lim_mode && wrapped) ? (s - m_lim) : (s & 64'hFFFF_FFFF);
      if (m_ctrl[11]) m_cap = m_cnt;
      if (ld) n_cnt = longint'(wr_data);
      else if (rs) n_cnt = 0;
      else if (run) n_cnt = nx;
      else n_cnt = m_cnt;
      if (rs) n_tc = 0;
      else if (run) n_tc = (m_trim == 0 || hit) ? 0 : m_tc + 1;
      else n_tc = m_tc;
      m_ovf = wrapped && !ld && !rs;
      m_cnt = n_cnt; m_tc = n_tc;
      if (wr_en && wr_addr == 3'd0) m_ctrl = longint'(wr_data) & 64'h2AB1;
      else m_ctrl = m_ctrl & ~64'hA00;
      if (wr_en && wr_addr == 3'd2) m_lim = longint'(wr_data);
      if (wr_en && wr_addr == 3'd3) m_trim = longint'(wr_data) & 64'h7FFF_FFFF;
      if (wr_en && wr_addr == 3'd4) m_steps = longint'(wr_data) & 64'h7F7F;
    end
  end

  function automatic longint unsigned exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_ctrl;
      3'd1: return m_cap;
      3'd2: return m_lim;
      3'd3: return m_trim;
      3'd4: return m_steps;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    #3;
    if (started && !done) begin
      longint unsigned e;
      e = exp_rd(rd_addr);
      vectors++;
      if (longint'(rd_data) != e) begin
        miscompares++;
        $display("FAIL %s addr %0d rd_data got %h exp %h", phase, rd_addr, rd_data, e[31:0]);
      end
      vectors++;
      if (ovf_pulse != m_ovf) begin
        miscompares++;
        $display("FAIL %s ovf_pulse got %0b exp %0b", phase, ovf_pulse, m_ovf);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sample_run(input logic [31:0] ctl, input int n);
    @(negedge clk) rd_addr = 3'd1;
    for (int i = 0; i < n; i++) begin
      wr(3'd0, ctl | 32'h800);
      idle(i % 3 + 1);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired in phase %s", phase);
    finish_run();
  end

  initial begin
    #1 rst_n = 1'b0;
    @(posedge clk);
    started = 1;
    for (int a = 0; a < 8; a++) begin
      @(negedge clk) rd_addr = 3'(a);         // R1 reset values
    end
    @(negedge clk) rst_n = 1'b1;
    for (int a = 0; a < 8; a++) begin
      @(negedge clk) rd_addr = 3'(a);         // R1 after release
    end

    phase = "R11 control bits";
    @(negedge clk) rd_addr = 3'd0;
    wr(3'd0, 32'h0000_2080);
    idle(2);
    wr(3'd0, 32'hFFFF_FFFF);                   // R11, self-clear R8 R10
    idle(3);
    wr(3'd0, 32'h0);
    for (int a = 5; a < 8; a++) begin
      @(negedge clk) rd_addr = 3'(a);
    end

    phase = "R3 normal step";
    wr(3'd4, 32'h0000_0008);
    @(negedge clk) rd_addr = 3'd4;
    wr(3'd0, 32'h1);
    sample_run(32'h1, 12);

    phase = "R2 stopped";
    wr(3'd0, 32'h0);
    sample_run(32'h0, 6);

    phase = "R4 trim fast";
    wr(3'd4, 32'h0000_0908);
    wr(3'd3, 32'd3);
    @(negedge clk) rd_addr = 3'd3;
    wr(3'd0, 32'h201);
    sample_run(32'h1, 16);

    phase = "R4 trim slow";
    wr(3'd4, 32'h0000_0508);
    wr(3'd3, 32'd4);
    sample_run(32'h1, 16);

    phase = "R5 trim off";
    wr(3'd3, 32'd0);
    sample_run(32'h1, 10);

    phase = "R6 limit wrap";
    wr(3'd2, 32'd100);
    @(negedge clk) rd_addr = 3'd2;
    wr(3'd3, 32'd2);
    wr(3'd0, 32'h231);
    sample_run(32'h31, 30);
    wr(3'd4, 32'h0000_7F08);                   // large trim step R6
    sample_run(32'h31, 20);

    phase = "R7 full wrap";
    wr(3'd3, 32'd0);
    wr(3'd4, 32'h0000_0008);
    wr(3'd0, 32'h1);
    wr(3'd1, 32'hFFFF_FFF0);
    sample_run(32'h1, 10);

    phase = "R9 load";
    wr(3'd1, 32'h1234_5678);
    wr(3'd0, 32'h801);
    idle(2);
    wr(3'd0, 32'h201);                          // restart then load same flow
    wr(3'd1, 32'h0000_0040);
    sample_run(32'h1, 6);

    phase = "R10 restart";
    wr(3'd0, 32'h201);
    wr(3'd0, 32'h801);
    idle(2);
    sample_run(32'h1, 6);

    phase = "R8 capture hold";
    @(negedge clk) rd_addr = 3'd1;
    idle(20);

    finish_run();
  end
endmodule